// File: doc/BRIEF.md
# Anchored Tag Pattern Matcher

This block is a hard-wired finite state machine that recognizes one fixed byte pattern: an opening byte `<`, then any run of bytes that are not `>`, then a closing `>`. It consumes at most one payload byte per clock. It is anchored at the byte on which it leaves idle. There is no implicit "any prefix" loop, so a match always begins exactly at the byte that started the machine.

An external controller chooses which byte to present next and backtracks on the events this block reports. A start event marks the first byte of a candidate substring. An accept event marks a byte that completes a member of the pattern language. A fail event marks the byte that can no longer extend the substring. After an accept, the match ends at the accepted byte, and the failing byte is not part of it. The controller forces the machine back to idle with a synchronous reset request at the end of each packet.

Once the closing byte has been accepted, no longer string can match. The byte after an accept therefore always fails, which makes the reported boundary the longest match.

Top module: `anchored_tag_matcher`

## Requirements
- R1: After `rst_n` is low at a clock edge, `running` is 0, and no `start`, `accept` or `fail` is raised until a byte is consumed.
- R2: While idle, a valid byte other than 0x3C raises no event, and `running` stays 0 after the edge.
- R3: While idle, a valid byte 0x3C raises `start` in the same cycle, and `running` is 1 after the edge.
- R4: While running and not yet accepted, a valid byte other than 0x3E (0x3C included) raises no event, and the machine stays running.
- R5: While running and not yet accepted, a valid byte 0x3E raises `accept` in the same cycle, and the machine stays running.
- R6: After an accept, the next valid byte of any value raises `fail` in the same cycle and never `start`, and `running` is 0 after the edge.
- R7: A cycle with `byte_valid` low raises no event and leaves the state unchanged.
- R8: `ctrl_reset` high takes priority over any byte: no event is raised in that cycle, and `running` is 0 after the edge.
- R9: At most one of `start`, `accept`, `fail` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_valid | input | 1 | A byte is presented on `data` this cycle |
| data | input | 8 | Payload byte |
| ctrl_reset | input | 1 | Controller request to return to idle |
| start | output | 1 | The current byte begins a candidate substring |
| accept | output | 1 | The current byte completes a match |
| fail | output | 1 | The current byte cannot extend the substring |
| running | output | 1 | Machine is out of idle (registered state) |

## Verification
A wrong internal state becomes visible in two ways, at the latest on the next valid byte. The first is the `running` output one edge after the byte that caused it. The second is the event pattern that byte produces, such as a missing `accept` on `>` or a spurious `start` on a byte that failed. The bench drives every byte value, both valid levels and the controller reset from each of the three states. After each edge it compares the same-cycle events and the following `running` with a model computed from the requirements. An error in the state therefore shows up within one cycle of its cause.

// File: rtl/tagm_pkg.sv
package tagm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_INSIDE = 2'd1,
        ST_CLOSED = 2'd2
    } tagm_state_e;

    typedef struct packed {
        tagm_state_e state;
        logic        start;
        logic        accept;
        logic        fail;
    } tagm_step_t;

endpackage

// File: rtl/tagm_byte_class.sv
module tagm_byte_class #(
    parameter int          DATA_W     = 8,
    parameter logic [7:0]  OPEN_CODE  = 8'h3C,
    parameter logic [7:0]  CLOSE_CODE = 8'h3E
) (
    input  logic [DATA_W-1:0] data,
    output logic              is_open,
    output logic              is_close
);
    localparam logic [DATA_W-1:0] OPEN_W  = DATA_W'(OPEN_CODE);
    localparam logic [DATA_W-1:0] CLOSE_W = DATA_W'(CLOSE_CODE);

    always_comb begin
        is_open  = (data == OPEN_W);
        is_close = (data == CLOSE_W);
    end
endmodule

// File: rtl/tagm_step.sv
module tagm_step
    import tagm_pkg::*;
(
    input  tagm_state_e state_q,
    input  logic        byte_valid,
    input  logic        ctrl_reset,
    input  logic        is_open,
    input  logic        is_close,
    output tagm_step_t  step_d
);
    always_comb begin
        step_d        = '0;
        step_d.state  = state_q;
        if (ctrl_reset) begin
            step_d.state = ST_IDLE;
        end else if (byte_valid) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (is_open) begin
                        step_d.start = 1'b1;
                        step_d.state = ST_INSIDE;
                    end
                end
                ST_INSIDE: begin
                    if (is_close) begin
                        step_d.accept = 1'b1;
                        step_d.state  = ST_CLOSED;
                    end
                end
                ST_CLOSED: begin
                    step_d.fail  = 1'b1;
                    step_d.state = ST_IDLE;
                end
                default: step_d.state = ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/anchored_tag_matcher.sv
module anchored_tag_matcher
    import tagm_pkg::*;
#(
    parameter int         DATA_W     = 8,
    parameter logic [7:0] OPEN_CODE  = 8'h3C,
    parameter logic [7:0] CLOSE_CODE = 8'h3E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] data,
    input  logic              ctrl_reset,
    output logic              start,
    output logic              accept,
    output logic              fail,
    output logic              running
);
    logic        is_open;
    logic        is_close;
    tagm_state_e state_q;
    tagm_step_t  step_d;

    tagm_byte_class #(
        .DATA_W    (DATA_W),
        .OPEN_CODE (OPEN_CODE),
        .CLOSE_CODE(CLOSE_CODE)
    ) u_class (
        .data    (data),
        .is_open (is_open),
        .is_close(is_close)
    );

    tagm_step u_step (
        .state_q   (state_q),
        .byte_valid(byte_valid),
        .ctrl_reset(ctrl_reset),
        .is_open   (is_open),
        .is_close  (is_close),
        .step_d    (step_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= step_d.state;
        end
    end

    always_comb begin
        start   = rst_n & step_d.start;
        accept  = rst_n & step_d.accept;
        fail    = rst_n & step_d.fail;
        running = (state_q != ST_IDLE);
    end
endmodule

// File: rtl/anchored_tag_matcher_chk.sv
module anchored_tag_matcher_chk (
    input logic clk,
    input logic rst_n,
    input logic byte_valid,
    input logic ctrl_reset,
    input logic start,
    input logic accept,
    input logic fail,
    input logic running
);
    a_r9_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start, accept, fail}));

    a_r7_no_event_without_byte: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_valid |-> !(start || accept || fail));

    a_r3_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !running);

    a_r3_start_then_running: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> running);

    a_r5_accept_while_running: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> running);

    a_r6_fail_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> !running);

    a_r8_ctrl_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_reset |-> !(start || accept || fail));

    a_r8_ctrl_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_reset |=> !running);
endmodule

bind anchored_tag_matcher anchored_tag_matcher_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_valid(byte_valid),
    .ctrl_reset(ctrl_reset),
    .start     (start),
    .accept    (accept),
    .fail      (fail),
    .running   (running)
);

// File: tb/anchored_tag_matcher_bench.sv
module anchored_tag_matcher_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_valid = 1'b0;
    logic [7:0] data = 8'h00;
    logic       ctrl_reset = 1'b0;
    logic       start, accept, fail, running;

    int n_checks = 0;
    int n_fails  = 0;
    int model    = 0;   // 0 idle, 1 inside, 2 closed
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    anchored_tag_matcher u_anchored_tag_matcher (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_valid(byte_valid),
        .data      (data),
        .ctrl_reset(ctrl_reset),
        .start     (start),
        .accept    (accept),
        .fail      (fail),
        .running   (running)
    );

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h (state %0d data %0h)",
                     req, what, act, exp, model, data);
        end
    endtask

    task automatic step(input logic v, input logic [7:0] b, input logic cr);
        logic es, ea, ef;
        int   nxt;
        string req;
        es = 0; ea = 0; ef = 0; nxt = model;
        if (cr) begin
            req = "R8"; nxt = 0;
        end else if (!v) begin
            req = "R7";
        end else if (model == 0) begin
            es  = (b == 8'h3C);
            req = es ? "R3" : "R2";
            nxt = es ? 1 : 0;
        end else if (model == 1) begin
            ea  = (b == 8'h3E);
            req = ea ? "R5" : "R4";
            nxt = ea ? 2 : 1;
        end else begin
            ef = 1; req = "R6"; nxt = 0;
        end
        @(negedge clk);
        byte_valid = v; data = b; ctrl_reset = cr;
        #1;
        chk(req, "start", {7'd0, start}, {7'd0, es});
        chk(req, "accept", {7'd0, accept}, {7'd0, ea});
        chk(req, "fail", {7'd0, fail}, {7'd0, ef});
        chk("R9", "event count", 8'($countones({start, accept, fail})),
            8'((start | accept | fail) ? 1 : 0));
        @(posedge clk);
        model = nxt;
        #1;
        byte_valid = 0; ctrl_reset = 0;
        chk(req, "running", {7'd0, running}, {7'd0, (model != 0)});
    endtask

    task automatic go_state(input int st);
        step(1'b0, 8'h00, 1'b1);
        if (st >= 1) step(1'b1, 8'h3C, 1'b0);
        if (st >= 2) step(1'b1, 8'h3E, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "running", {7'd0, running}, 8'd0);
        chk("R1", "events", {5'd0, start, accept, fail}, 8'd0);
        rst_n = 1'b1;
        // reset mid-match returns to idle (R1)
        step(1'b1, 8'h3C, 1'b0);
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1; model = 0;
        chk("R1", "running after reset", {7'd0, running}, 8'd0);
        rst_n = 1'b1;
        for (int st = 0; st < 3; st++) begin
            for (int b = 0; b < 256; b++) begin
                for (int v = 0; v < 2; v++) begin
                    go_state(st);
                    step(v[0], 8'(b), 1'b0);
                    // follow-up byte exposes the resulting state
                    step(1'b1, 8'h41, 1'b0);
                end
            end
            go_state(st);
            step(1'b1, 8'h3C, 1'b1);
            go_state(st);
            step(1'b1, 8'h3E, 1'b1);
        end
        // a full tag with a nested opener, then a fail on '<' (R4, R5, R6)
        go_state(0);
        step(1'b1, 8'h3C, 1'b0);
        step(1'b1, 8'h3C, 1'b0);
        step(1'b1, 8'h61, 1'b0);
        step(1'b0, 8'h3E, 1'b0);
        step(1'b1, 8'h3E, 1'b0);
        step(1'b0, 8'h3C, 1'b0);
        step(1'b1, 8'h3C, 1'b0);
        step(1'b1, 8'h3C, 1'b0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end
endmodule